// File: doc/BRIEF.md
# Word-Parallel Maximal-Length Scrambler

This block whitens a parallel data path. Each accepted input word is combined by XOR with the next WORD_W bits of a serial maximal-length pseudorandom sequence, so that multiplexing the output words least-significant bit first gives the same stream as a serial scrambler running at WORD_W times the clock rate. The default generator is the seven-stage recurrence s[n] = s[n-6] XOR s[n-7], with a period of 127 bits. A parameter selects the eleven-stage recurrence s[n] = s[n-9] XOR s[n-11] instead, with a period of 2047 bits.

A seed fixes the first SEED_W bits of the sequence. After reset or a seed load, a short serial fill phase expands the seed into a two-word history. The block then moves to its running state. In the running state, every bit of the next word is one two-input XOR of two bits already held in that history, so each output port costs one XOR2 and one register. The controller has two states. FILL shifts one new sequence bit into the history per clock. RUN hands out one word per accepted input. The transitions are: reset or seed load from any state to FILL; FILL to RUN when the fill counter expires; RUN stays in RUN until a load.

Top module: `par_prbs_scrambler`

## Requirements
- R1: While reset is high, and on the first clock after it, out_valid, scr_word and prbs_word are zero and ready is low. Reset loads an all-ones seed. ready rises on the 2*WORD_W-SEED_W'th rising edge after reset is released, which is edge 25 for the default configuration.
- R2: With POLY_SEL=0, bit i of the k-th accepted word after seeding (k counted from 0) in prbs_word is s[16k+i]. Here s[t]=seed[t] for t<7 (seed bit 0 is s[0]) and s[n]=s[n-6]^s[n-7].
- R3: With POLY_SEL=1, the seed is 11 bits wide, s[n]=s[n-9]^s[n-11], and ready rises on edge 21 after reset or a load.
- R4: scr_word equals data_in XOR the PRBS word. It appears, together with prbs_word and a high out_valid, in the cycle after the edge that accepted the word.
- R5: A word is accepted only on an edge where ready and data_valid are high and seed_load is low. When no word is accepted, out_valid is low in the next cycle, scr_word and prbs_word hold their values, and the sequence does not advance.
- R6: data_valid while ready is low is ignored. No output appears, and the first word accepted afterwards is s[0..15].
- R7: seed_load restarts the fill from the new seed, in any state and also during a fill. It wins over a data_valid in the same cycle: ready and out_valid are low in the next cycle, and ready rises again after the fill length.
- R8: A load of an all-zero seed loads an all-ones seed instead, so the generator state never becomes all zeros.
- R9: The word stream repeats with the period of the sequence: accepted word k+127 equals word k for POLY_SEL=0, and word k+2047 equals word k for POLY_SEL=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the all-ones seed |
| seed_load | input | 1 | Load seed and restart the fill |
| seed | input | SEED_W | Initial sequence bits, bit 0 first |
| data_valid | input | 1 | data_in carries a word |
| data_in | input | WORD_W | Plain data word |
| ready | output | 1 | Generator in RUN; words are accepted |
| out_valid | output | 1 | Scrambled word present |
| scr_word | output | WORD_W | data_in XOR PRBS word |
| prbs_word | output | WORD_W | Raw PRBS word used for scr_word |

## Verification
A seed load and the acceptance of a data word can both be requested on the same edge, and the load must win. The bench asserts seed_load and data_valid together in the middle of a stream. It expects no output in the next cycle, ready low, a fill of exactly the stated length, and then the sequence restarting from the new seed. Loads issued during a fill, and data_valid held high throughout a fill, are judged the same way. This checks that no word leaks out and that the restart count is right.

// File: rtl/pscr_pkg.sv
package pscr_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } pscr_state_e;

    // Longest tap (number of stages) of the selected recurrence.
    function automatic int poly_len(input int sel);
        return (sel == 1) ? 11 : 7;
    endfunction

    // Shorter tap of the selected recurrence.
    function automatic int poly_tap(input int sel);
        return (sel == 1) ? 9 : 6;
    endfunction

    // Smallest power of two k with k*short_tap >= width. The recurrence
    // raised to the k-th power still holds, and with this k both of its
    // taps fall inside the two previously held words.
    function automatic int stride_for(input int sel, input int width);
        int k;
        k = 1;
        for (int p = 0; p < 16; p++) begin
            if (k * poly_tap(sel) < width) k = k * 2;
        end
        return k;
    endfunction

endpackage

// File: rtl/pscr_ctrl.sv
module pscr_ctrl
    import pscr_pkg::*;
#(
    parameter int FILL_CYCLES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic seed_load,
    input  logic data_valid,
    output logic load_en,
    output logic shift_en,
    output logic adv_en,
    output logic ready
);
    localparam int CNT_W = (FILL_CYCLES > 1) ? $clog2(FILL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILL_CYCLES - 1);

    pscr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst || seed_load) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (cnt_q == LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // Outputs
    always_comb begin
        load_en  = rst | seed_load;
        shift_en = 1'b0;
        adv_en   = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            ST_FILL: shift_en = ~load_en;
            ST_RUN: begin
                ready  = 1'b1;
                adv_en = data_valid & ~load_en;
            end
            default: ;
        endcase
    end

    // R7
    load_restart_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !ready);

    // R1
    fill_length_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(cnt_q) == LAST);

    // R5
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready && !seed_load |=> ready);

endmodule

// File: rtl/pscr_hist.sv
module pscr_hist #(
    parameter int WORD_W = 16,
    parameter int SEED_W = 7,
    parameter int TAP    = 6,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [SEED_W-1:0] seed,
    input  logic              shift_en,
    input  logic              adv_en,
    output logic [WORD_W-1:0] cur_word
);
    localparam int HW = 2 * WORD_W;
    localparam int FB_A = HW - SEED_W;
    localparam int FB_B = HW - TAP;

    // hist[t] holds sequence bit base+t; the low word is the next word out.
    logic [HW-1:0]     hist_q;
    logic [SEED_W-1:0] seed_eff;
    logic              fill_bit;
    logic [WORD_W-1:0] next_word;

    // Reset and the all-zero seed both fall back to all ones.
    assign seed_eff = (rst || (seed == '0)) ? '1 : seed;

    // Serial fill: the oldest R bits of the window sit at the top.
    assign fill_bit = hist_q[FB_A] ^ hist_q[FB_B];

    // One XOR2 per port, both inputs taken from registered history.
    for (genvar i = 0; i < WORD_W; i++) begin : g_port
        localparam int IA = HW + i - STRIDE * TAP;
        localparam int IB = HW + i - STRIDE * SEED_W;
        assign next_word[i] = hist_q[IA] ^ hist_q[IB];
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            hist_q <= {seed_eff, {(HW - SEED_W){1'b0}}};
        end else if (shift_en) begin
            hist_q <= {fill_bit, hist_q[HW-1:1]};
        end else if (adv_en) begin
            hist_q <= {next_word, hist_q[HW-1:WORD_W]};
        end
    end

    assign cur_word = hist_q[WORD_W-1:0];

    // R8
    no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
        hist_q[HW-1 -: SEED_W] != '0);

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en && !shift_en && !adv_en |=> $stable(hist_q));

endmodule

// File: rtl/pscr_out.sv
module pscr_out #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] data_in,
    input  logic [WORD_W-1:0] prbs_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] scr_word,
    output logic [WORD_W-1:0] prbs_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            scr_word  <= '0;
            prbs_word <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                scr_word  <= data_in ^ prbs_in;
                prbs_word <= prbs_in;
            end
        end
    end

    // R4
    scramble_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (scr_word ^ prbs_word) == $past(data_in));

endmodule

// File: rtl/par_prbs_scrambler.sv
module par_prbs_scrambler
    import pscr_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int POLY_SEL = 0,
    localparam int SEED_W  = poly_len(POLY_SEL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [SEED_W-1:0] seed,
    input  logic              data_valid,
    input  logic [WORD_W-1:0] data_in,
    output logic              ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] scr_word,
    output logic [WORD_W-1:0] prbs_word
);
    localparam int TAP    = poly_tap(POLY_SEL);
    localparam int STRIDE = stride_for(POLY_SEL, WORD_W);
    localparam int FILL   = 2 * WORD_W - SEED_W;

    logic              load_en;
    logic              shift_en;
    logic              adv_en;
    logic [WORD_W-1:0] cur_word;

    pscr_ctrl #(.FILL_CYCLES(FILL)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .seed_load  (seed_load),
        .data_valid (data_valid),
        .load_en    (load_en),
        .shift_en   (shift_en),
        .adv_en     (adv_en),
        .ready      (ready)
    );

    pscr_hist #(
        .WORD_W (WORD_W),
        .SEED_W (SEED_W),
        .TAP    (TAP),
        .STRIDE (STRIDE)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .seed     (seed),
        .shift_en (shift_en),
        .adv_en   (adv_en),
        .cur_word (cur_word)
    );

    pscr_out #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .accept    (adv_en),
        .data_in   (data_in),
        .prbs_in   (cur_word),
        .out_valid (out_valid),
        .scr_word  (scr_word),
        .prbs_word (prbs_word)
    );

    // R6
    accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(ready));

endmodule

// File: tb/tb_par_prbs_scrambler.sv
`timescale 1ns/1ps
module tb_par_prbs_scrambler;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_a, ld_b, dv_a, dv_b;
    logic [15:0] din;
    logic [6:0]  seed_a;
    logic [10:0] seed_b;
    logic        rdy_a, ov_a, rdy_b, ov_b;
    logic [15:0] scr_a, prbs_a, scr_b, prbs_b;

    int nvec = 0;
    int nfail = 0;
    bit ref_a [0:126];
    bit ref_b [0:2046];
    int ptr_a, ptr_b, acc_a, acc_b;
    logic [15:0] last_a, last_b;

    always #10 clk = ~clk;

    par_prbs_scrambler #(.WORD_W(16), .POLY_SEL(0)) dut (
        .clk(clk), .rst(rst), .seed_load(ld_a), .seed(seed_a),
        .data_valid(dv_a), .data_in(din), .ready(rdy_a),
        .out_valid(ov_a), .scr_word(scr_a), .prbs_word(prbs_a));

    par_prbs_scrambler #(.WORD_W(16), .POLY_SEL(1)) dut_b (
        .clk(clk), .rst(rst), .seed_load(ld_b), .seed(seed_b),
        .data_valid(dv_b), .data_in(din), .ready(rdy_b),
        .out_valid(ov_b), .scr_word(scr_b), .prbs_word(prbs_b));

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Serial reference sequences, computed bit by bit.
    task automatic build(input int sel, input logic [10:0] sd);
        if (sel == 0) begin
            logic [6:0] e;
            e = (sd[6:0] == 7'd0) ? 7'h7F : sd[6:0];
            for (int t = 0; t < 7; t++) ref_a[t] = e[t];
            for (int t = 7; t < 127; t++) ref_a[t] = ref_a[t-6] ^ ref_a[t-7];
            ptr_a = 0; acc_a = 0;
        end else begin
            logic [10:0] e;
            e = (sd == 11'd0) ? 11'h7FF : sd;
            for (int t = 0; t < 11; t++) ref_b[t] = e[t];
            for (int t = 11; t < 2047; t++) ref_b[t] = ref_b[t-9] ^ ref_b[t-11];
            ptr_b = 0; acc_b = 0;
        end
    endtask

    function automatic logic [15:0] expw(input int sel);
        logic [15:0] w;
        for (int i = 0; i < 16; i++)
            w[i] = (sel == 0) ? ref_a[(ptr_a + i) % 127] : ref_b[(ptr_b + i) % 2047];
        return w;
    endfunction

    task automatic push(input int sel, input logic [15:0] d, input logic v, input string req);
        logic r, ov;
        logic [15:0] e, pw, sw;
        r = (sel == 0) ? rdy_a : rdy_b;
        e = expw(sel);
        din = d;
        if (sel == 0) dv_a = v; else dv_b = v;
        @(posedge clk);
        @(negedge clk);
        dv_a = 1'b0; dv_b = 1'b0;
        ov = (sel == 0) ? ov_a : ov_b;
        pw = (sel == 0) ? prbs_a : prbs_b;
        sw = (sel == 0) ? scr_a : scr_b;
        if (v && r) begin
            chk(req, 32'(ov), 32'd1);
            chk(req, 32'(pw), 32'(e));
            chk(req, 32'(sw), 32'(d ^ e));
            if (sel == 0) begin
                ptr_a = (ptr_a + 16) % 127; acc_a++; last_a = e;
            end else begin
                ptr_b = (ptr_b + 16) % 2047; acc_b++; last_b = e;
            end
        end else begin
            chk(req, 32'(ov), 32'd0);
            chk(req, 32'(pw), 32'((sel == 0) ? last_a : last_b));
        end
    endtask

    task automatic do_load(input int sel, input logic [10:0] sd, input logic with_dv,
                           input logic wait_it, input string req);
        int n;
        logic r, ov;
        if (sel == 0) begin ld_a = 1'b1; seed_a = sd[6:0]; dv_a = with_dv; end
        else begin ld_b = 1'b1; seed_b = sd; dv_b = with_dv; end
        din = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        ld_a = 1'b0; ld_b = 1'b0; dv_a = 1'b0; dv_b = 1'b0;
        build(sel, sd);
        r  = (sel == 0) ? rdy_a : rdy_b;
        ov = (sel == 0) ? ov_a : ov_b;
        chk(req, 32'(r), 32'd0);
        chk(req, 32'(ov), 32'd0);
        if (wait_it) begin
            n = 1;
            r = 1'b0;
            while (!r && n < 100) begin
                @(posedge clk);
                @(negedge clk);
                n++;
                r = (sel == 0) ? rdy_a : rdy_b;
            end
            chk(req, 32'(n - 1), (sel == 0) ? 32'd25 : 32'd21);
        end
    endtask

    function automatic logic [15:0] pattern(input int k);
        case (k % 5)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'(k * 40503);
            3: return (k % 2 == 0) ? 16'hAAAA : 16'h5555;
            default: return 16'h0001 << (k % 16);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int na, nb, n;
        rst = 1'b1; ld_a = 1'b0; ld_b = 1'b0; dv_a = 1'b0; dv_b = 1'b0;
        din = '0; seed_a = '0; seed_b = '0;
        last_a = '0; last_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(rdy_a), 32'd0);
        chk("R1", 32'(ov_a), 32'd0);
        chk("R1", 32'(prbs_a), 32'd0);
        chk("R1", 32'(scr_a), 32'd0);
        chk("R1", 32'(rdy_b), 32'd0);
        rst = 1'b0;
        build(0, 11'd0);
        build(1, 11'd0);
        // R6 data_valid held through the fill; fill lengths R1 / R3
        dv_a = 1'b1; dv_b = 1'b1; din = 16'hFFFF;
        na = 0; nb = 0; n = 0;
        while ((na == 0 || nb == 0) && n < 100) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            chk("R6", 32'(ov_a | ov_b), 32'd0);
            if (rdy_a && na == 0) begin na = n; dv_a = 1'b0; end
            if (rdy_b && nb == 0) begin nb = n; dv_b = 1'b0; end
        end
        dv_a = 1'b0; dv_b = 1'b0;
        chk("R1", 32'(na), 32'd25);
        chk("R3", 32'(nb), 32'd21);
        chk("R6", 32'(ov_a | ov_b), 32'd0);

        // Default polynomial: long stream with gaps, beyond one period
        for (int k = 0; k < 300; k++) begin
            logic v;
            v = (k % 7) != 3;
            if (!v) push(0, pattern(k), 1'b0, "R5");
            else if (acc_a >= 127) push(0, pattern(k), 1'b1, "R9");
            else if (k % 5 == 2) push(0, pattern(k), 1'b1, "R4");
            else push(0, pattern(k), 1'b1, "R2");
        end

        // R7 load together with data_valid, mid-stream
        do_load(0, 11'h035, 1'b1, 1'b1, "R7");
        for (int k = 0; k < 20; k++) push(0, pattern(k + 3), 1'b1, "R7");

        // R8 zero seed
        do_load(0, 11'h000, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 12; k++) push(0, pattern(k), 1'b1, "R8");

        // R7 reload during a fill
        do_load(0, 11'h012, 1'b0, 1'b0, "R7");
        repeat (5) push(0, 16'hBEEF, 1'b1, "R6");
        do_load(0, 11'h061, 1'b0, 1'b1, "R7");
        for (int k = 0; k < 12; k++) push(0, pattern(k), 1'b1, "R7");

        // Eleven-stage polynomial: beyond one period
        for (int k = 0; k < 2100; k++) begin
            logic v;
            v = (k % 11) != 5;
            if (!v) push(1, pattern(k), 1'b0, "R5");
            else if (acc_b >= 2047) push(1, pattern(k), 1'b1, "R9");
            else push(1, pattern(k), 1'b1, "R3");
        end
        do_load(1, 11'h5A3, 1'b1, 1'b1, "R7");
        for (int k = 0; k < 40; k++) push(1, pattern(k), 1'b1, "R3");
        do_load(1, 11'h000, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 10; k++) push(1, pattern(k), 1'b1, "R8");

        summary();
        $finish;
    end

endmodule